// File: doc/BRIEF.md
# Raster Timing Generator with Interlaced Fields

This block produces the raster timing for a video output. Each cycle in which the tick enable is high, a tick-in-line counter advances. When a line ends, a line counter advances, and when a frame ends the line counter wraps. The line length and the frame height come from a region select: a 50 Hz frame has 314 lines of 3406 ticks, and a 60 Hz frame has 263 lines of 3413 ticks. Programmable horizontal and vertical display windows turn the two counters into horizontal and vertical blanking levels. The block also gives a one-cycle pulse when vertical blanking starts, for use as an interrupt request. It gives a one-cycle pulse when horizontal blanking starts, so that an external counter can count lines. A gate output follows vertical blanking.

Alongside the raster, the block tracks the interlace field and an odd/even line flag. From the horizontal-resolution selects it reports the dot-clock divider, and it reports the visible picture width and height. All configuration inputs are captured into a shadow register only at a line boundary, so no line is timed with a mix of old and new settings. The tick enable lets the caller run the counters at any fraction of the block clock.

Top module: `vtg_top`

## Requirements
- R1: After reset the tick count, line count and field are 0, and neither pulse output is high. The shadow configuration holds its defaults: 60 Hz, no interlace, divider select 0, horizontal window 608..3168, vertical window 16..255, display Y 0.
- R2: The tick count changes only in cycles where tick_en is high. When it would reach the line total (3406 ticks when the shadow region bit is 1, 3413 when it is 0), it returns to 0 and the line count increments.
- R3: When the line count would reach the frame total (314 lines for region 1, 263 for region 0), a new frame starts. With interlace off, the field is forced to 0 and the line count restarts at 0. With interlace on, the field inverts, and the line count restarts at 1 if the new field is 0 and at 0 if the new field is 1.
- R4: All configuration inputs are copied into the shadow configuration on the tick_en cycle that ends a line, and only then. Every output except the counters is derived from the shadow copy.
- R5: The horizontal start and end are each clamped to the line total. hblank is 1 when the tick count is below the clamped start or at or above the clamped end.
- R6: The vertical start and end are each clamped to the frame total. vblank is 1 when the line count is below the clamped start or at or above the clamped end.
- R7: hblank_pulse is high for exactly the one cycle in which hblank has just gone from 0 to 1.
- R8: vblank_irq is high for exactly the one cycle in which vblank has just gone from 0 to 1, and timer_gate equals vblank.
- R9: dot_div is looked up with the index {hres_hi, hres_lo[1:0]} from the table 10, 8, 5, 4, 7, 7, 7, 7, for index 0 to 7.
- R10: vis_width is (clamped end − clamped start) / dot_div, rounded down. It is 1 when that quotient is 0 or when the end is not above the start.
- R11: vis_height is (clamped vertical end − clamped vertical start), or 0 when the end is not above the start. It is doubled in 480-line interlaced mode, which means interlace on and tall_mode set.
- R12: In 480-line interlaced mode, even_line is bit 0 of (disp_y + inverted field). Otherwise it is bit 0 of (disp_y + line count).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Advances the raster by one tick |
| region_sel | input | 1 | 1 selects 314 lines of 3406 ticks, 0 selects 263 lines of 3413 ticks |
| interlace | input | 1 | Enables field alternation |
| tall_mode | input | 1 | With interlace, selects 480-line mode |
| hres_lo | input | 2 | Low bits of the divider index |
| hres_hi | input | 1 | High bit of the divider index |
| h_start | input | 12 | Horizontal display start tick |
| h_end | input | 12 | Horizontal display end tick |
| v_start | input | 10 | Vertical display start line |
| v_end | input | 10 | Vertical display end line |
| disp_y | input | 10 | Display origin row, used for the even-line flag |
| tick_cnt | output | 12 | Tick within the line |
| line_cnt | output | 9 | Line within the frame |
| field | output | 1 | Current interlace field |
| hblank | output | 1 | Horizontal blanking level |
| vblank | output | 1 | Vertical blanking level |
| hblank_pulse | output | 1 | One-cycle pulse on hblank entry |
| vblank_irq | output | 1 | One-cycle pulse on vblank entry |
| timer_gate | output | 1 | Gate that follows vblank |
| even_line | output | 1 | Odd/even line flag |
| dot_div | output | 4 | Selected dot-clock divider |
| vis_width | output | 12 | Visible width in dots |
| vis_height | output | 11 | Visible height in lines |

## Verification
The bench goes after a configuration change written in the middle of a line. A design that latched the change at once would end that line at the wrong total and shift every later blanking edge. In interlace, it checks that a frame whose new field is 0 starts at line 1. A design that always restarted at 0 would put the even-line flag and the vblank entry one line off in alternate frames. Windows that run past the totals, and a horizontal end below the start, check the clamping, the width floor of 1 and the zero height. A design that skipped those cases would blank the wrong ticks or report a width of 0. The bench also walks all eight divider indices, which catches any error in the odd upper half of the table.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int T_W = 12;
  localparam int L_W = 9;
  localparam int X_W = 12;
  localparam int Y_W = 10;

  typedef struct packed {
    logic           pal;
    logic           il;
    logic           tall;
    logic [2:0]     hsel;
    logic [X_W-1:0] x1;
    logic [X_W-1:0] x2;
    logic [Y_W-1:0] y1;
    logic [Y_W-1:0] y2;
    logic [Y_W-1:0] dy;
  } vcfg_t;

  function automatic logic [3:0] div_lookup(input logic [2:0] idx);
    logic [3:0] d;
    case (idx)
      3'd0:    d = 4'd10;
      3'd1:    d = 4'd8;
      3'd2:    d = 4'd5;
      3'd3:    d = 4'd4;
      default: d = 4'd7;
    endcase
    return d;
  endfunction

  function automatic logic [X_W-1:0] div_by(input logic [X_W-1:0] v, input logic [3:0] d);
    logic [X_W-1:0] q;
    case (d)
      4'd10:   q = v / X_W'(10);
      4'd8:    q = v >> 3;
      4'd5:    q = v / X_W'(5);
      4'd4:    q = v >> 2;
      default: q = v / X_W'(7);
    endcase
    return q;
  endfunction

  function automatic logic [X_W-1:0] clamp_x(input logic [X_W-1:0] v, input logic [T_W-1:0] lim);
    return (v > X_W'(lim)) ? X_W'(lim) : v;
  endfunction

  function automatic logic [Y_W-1:0] clamp_y(input logic [Y_W-1:0] v, input logic [L_W-1:0] lim);
    return (v > Y_W'(lim)) ? Y_W'(lim) : v;
  endfunction

  function automatic logic parity_of_sum(input logic [Y_W-1:0] a, input logic [Y_W-1:0] b);
    logic [Y_W-1:0] s;
    s = a + b;
    return s[0];
  endfunction

endpackage

// File: rtl/vtg_cfg_latch.sv
module vtg_cfg_latch
  import vtg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  vcfg_t cfg_in,
  output vcfg_t cfg_q
);

  localparam vcfg_t CFG_RESET = '{
    pal:  1'b0,
    il:   1'b0,
    tall: 1'b0,
    hsel: 3'd0,
    x1:   X_W'(608),
    x2:   X_W'(3168),
    y1:   Y_W'(16),
    y2:   Y_W'(255),
    dy:   '0
  };

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (load) begin
      cfg_q <= cfg_in;
    end
  end

endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic [T_W-1:0] htot,
  input  logic [L_W-1:0] vtot,
  input  logic           il,
  output logic [T_W-1:0] tick,
  output logic [L_W-1:0] line,
  output logic           field,
  output logic           line_wrap,
  output logic           frame_wrap
);

  logic [T_W:0] tick_inc;
  logic [L_W:0] line_inc;

  always_comb begin
    tick_inc   = (T_W+1)'(tick) + (T_W+1)'(1);
    line_inc   = (L_W+1)'(line) + (L_W+1)'(1);
    line_wrap  = tick_en && (tick_inc >= (T_W+1)'(htot));
    frame_wrap = line_wrap && (line_inc >= (L_W+1)'(vtot));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick  <= '0;
      line  <= '0;
      field <= 1'b0;
    end else if (tick_en) begin
      if (line_wrap) begin
        tick <= '0;
        if (frame_wrap) begin
          if (il) begin
            field <= ~field;
            line  <= field ? L_W'(1) : L_W'(0);
          end else begin
            field <= 1'b0;
            line  <= '0;
          end
        end else begin
          line <= line_inc[L_W-1:0];
        end
      end else begin
        tick <= tick_inc[T_W-1:0];
      end
    end
  end

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
(
  input  vcfg_t          cfg,
  input  logic [T_W-1:0] htot,
  input  logic [L_W-1:0] vtot,
  input  logic [T_W-1:0] tick,
  input  logic [L_W-1:0] line,
  input  logic           field,
  output logic           hblank,
  output logic           vblank,
  output logic           even_line,
  output logic [3:0]     dot_div,
  output logic [X_W-1:0] vis_width,
  output logic [Y_W:0]   vis_height
);

  logic [X_W-1:0] hs, he, span_x, quo;
  logic [Y_W-1:0] vs, ve, span_y;
  logic           mode_480i;

  always_comb begin
    hs = clamp_x(cfg.x1, htot);
    he = clamp_x(cfg.x2, htot);
    vs = clamp_y(cfg.y1, vtot);
    ve = clamp_y(cfg.y2, vtot);

    hblank = (X_W'(tick) < hs) || (X_W'(tick) >= he);
    vblank = (Y_W'(line) < vs) || (Y_W'(line) >= ve);

    dot_div = div_lookup(cfg.hsel);
    span_x  = (he > hs) ? (he - hs) : '0;
    quo     = div_by(span_x, dot_div);
    vis_width = (quo == '0) ? X_W'(1) : quo;

    mode_480i  = cfg.il && cfg.tall;
    span_y     = (ve > vs) ? (ve - vs) : '0;
    vis_height = mode_480i ? {span_y, 1'b0} : {1'b0, span_y};

    even_line = mode_480i ? parity_of_sum(cfg.dy, Y_W'(~field))
                          : parity_of_sum(cfg.dy, Y_W'(line));
  end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int PAL_LINES  = 314,
  parameter int PAL_TICKS  = 3406,
  parameter int NTSC_LINES = 263,
  parameter int NTSC_TICKS = 3413
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           region_sel,
  input  logic           interlace,
  input  logic           tall_mode,
  input  logic [1:0]     hres_lo,
  input  logic           hres_hi,
  input  logic [11:0]    h_start,
  input  logic [11:0]    h_end,
  input  logic [9:0]     v_start,
  input  logic [9:0]     v_end,
  input  logic [9:0]     disp_y,
  output logic [11:0]    tick_cnt,
  output logic [8:0]     line_cnt,
  output logic           field,
  output logic           hblank,
  output logic           vblank,
  output logic           hblank_pulse,
  output logic           vblank_irq,
  output logic           timer_gate,
  output logic           even_line,
  output logic [3:0]     dot_div,
  output logic [11:0]    vis_width,
  output logic [10:0]    vis_height
);

  vcfg_t          cfg_in, cfg_q;
  logic [T_W-1:0] htot;
  logic [L_W-1:0] vtot;
  logic           line_wrap, frame_wrap;
  logic           cfg_il;
  logic           hb_q, vb_q;

  always_comb begin
    cfg_in.pal  = region_sel;
    cfg_in.il   = interlace;
    cfg_in.tall = tall_mode;
    cfg_in.hsel = {hres_hi, hres_lo};
    cfg_in.x1   = h_start;
    cfg_in.x2   = h_end;
    cfg_in.y1   = v_start;
    cfg_in.y2   = v_end;
    cfg_in.dy   = disp_y;
  end

  assign htot   = cfg_q.pal ? T_W'(PAL_TICKS) : T_W'(NTSC_TICKS);
  assign vtot   = cfg_q.pal ? L_W'(PAL_LINES) : L_W'(NTSC_LINES);
  assign cfg_il = cfg_q.il;

  vtg_cfg_latch u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (line_wrap),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  vtg_counters u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .htot       (htot),
    .vtot       (vtot),
    .il         (cfg_q.il),
    .tick       (tick_cnt),
    .line       (line_cnt),
    .field      (field),
    .line_wrap  (line_wrap),
    .frame_wrap (frame_wrap)
  );

  vtg_decode u_dec (
    .cfg        (cfg_q),
    .htot       (htot),
    .vtot       (vtot),
    .tick       (tick_cnt),
    .line       (line_cnt),
    .field      (field),
    .hblank     (hblank),
    .vblank     (vblank),
    .even_line  (even_line),
    .dot_div    (dot_div),
    .vis_width  (vis_width),
    .vis_height (vis_height)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_q <= 1'b1;
      vb_q <= 1'b1;
    end else begin
      hb_q <= hblank;
      vb_q <= vblank;
    end
  end

  assign hblank_pulse = hblank && !hb_q;
  assign vblank_irq   = vblank && !vb_q;
  assign timer_gate   = vblank;

endmodule

// File: rtl/vtg_check.sv
module vtg_check (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic [11:0] tick_cnt,
  input logic [8:0]  line_cnt,
  input logic        field,
  input logic        hblank,
  input logic        vblank,
  input logic        hblank_pulse,
  input logic        vblank_irq,
  input logic        timer_gate,
  input logic [3:0]  dot_div,
  input logic [11:0] vis_width,
  input logic        line_wrap,
  input logic        frame_wrap,
  input logic        cfg_il
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(tick_cnt) && $stable(line_cnt)));

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_wrap |=> (tick_cnt == 12'd0));

  p_flat_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && !cfg_il) |=> !field);

  p_field_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && cfg_il) |=> (field != $past(field)));

  p_hpulse_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_pulse |-> hblank);

  p_hpulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_pulse |=> !hblank_pulse);

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |-> (vblank && timer_gate));

  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq |=> !vblank_irq);

  p_div_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_div == 4'd10) || (dot_div == 4'd8) || (dot_div == 4'd5) ||
    (dot_div == 4'd4) || (dot_div == 4'd7));

  p_width_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vis_width != 12'd0);

endmodule

bind vtg_top vtg_check u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_en      (tick_en),
  .tick_cnt     (tick_cnt),
  .line_cnt     (line_cnt),
  .field        (field),
  .hblank       (hblank),
  .vblank       (vblank),
  .hblank_pulse (hblank_pulse),
  .vblank_irq   (vblank_irq),
  .timer_gate   (timer_gate),
  .dot_div      (dot_div),
  .vis_width    (vis_width),
  .line_wrap    (line_wrap),
  .frame_wrap   (frame_wrap),
  .cfg_il       (cfg_il)
);

// File: tb/vtg_top_test.sv
module vtg_top_test;

  localparam int SP_L = 12, SP_T = 30, SN_L = 10, SN_T = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  bit run_chk = 0;

  // small instance stimulus
  logic       te = 1'b0, rsel = 1'b0, il = 1'b0, tall = 1'b0, hhi = 1'b0;
  logic [1:0] hlo = '0;
  logic [11:0] xs = '0, xe = '0;
  logic [9:0]  ys = '0, ye = '0, dy = '0;

  logic [11:0] o_tick, o_w;
  logic [8:0]  o_line;
  logic        o_field, o_hb, o_vb, o_hp, o_irq, o_gate, o_even;
  logic [3:0]  o_div;
  logic [10:0] o_h;

  vtg_top #(.PAL_LINES(SP_L), .PAL_TICKS(SP_T), .NTSC_LINES(SN_L), .NTSC_TICKS(SN_T)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(te), .region_sel(rsel), .interlace(il),
    .tall_mode(tall), .hres_lo(hlo), .hres_hi(hhi), .h_start(xs), .h_end(xe),
    .v_start(ys), .v_end(ye), .disp_y(dy),
    .tick_cnt(o_tick), .line_cnt(o_line), .field(o_field), .hblank(o_hb), .vblank(o_vb),
    .hblank_pulse(o_hp), .vblank_irq(o_irq), .timer_gate(o_gate), .even_line(o_even),
    .dot_div(o_div), .vis_width(o_w), .vis_height(o_h));

  // full-size instance
  logic        f_pal = 1'b0;
  logic [11:0] f_tick, f_w;
  logic [8:0]  f_line;
  logic        f_field, f_hb, f_vb, f_hp, f_irq, f_gate, f_even;
  logic [3:0]  f_div;
  logic [10:0] f_h;

  vtg_top uut_full (
    .clk(clk), .rst_n(rst_n), .tick_en(1'b1), .region_sel(f_pal), .interlace(1'b0),
    .tall_mode(1'b0), .hres_lo(2'd0), .hres_hi(1'b0), .h_start(12'd608), .h_end(12'd3168),
    .v_start(10'd16), .v_end(10'd255), .disp_y(10'd0),
    .tick_cnt(f_tick), .line_cnt(f_line), .field(f_field), .hblank(f_hb), .vblank(f_vb),
    .hblank_pulse(f_hp), .vblank_irq(f_irq), .timer_gate(f_gate), .even_line(f_even),
    .dot_div(f_div), .vis_width(f_w), .vis_height(f_h));

  // reference model state
  int m_tick, m_line, m_field, m_pal, m_il, m_tall, m_hsel, m_x1, m_x2, m_y1, m_y2, m_dy;
  int m_hbp, m_vbp;
  int divtab[8] = '{10, 8, 5, 4, 7, 7, 7, 7};

  function automatic int lim(int v, int top);
    return (v > top) ? top : v;
  endfunction
  function automatic int e_ht();  return m_pal ? SP_T : SN_T; endfunction
  function automatic int e_vt();  return m_pal ? SP_L : SN_L; endfunction
  function automatic int e_hb();
    int a = lim(m_x1, e_ht()), b = lim(m_x2, e_ht());
    return (m_tick < a || m_tick >= b) ? 1 : 0;
  endfunction
  function automatic int e_vb();
    int a = lim(m_y1, e_vt()), b = lim(m_y2, e_vt());
    return (m_line < a || m_line >= b) ? 1 : 0;
  endfunction
  function automatic int e_w();
    int d = lim(m_x2, e_ht()) - lim(m_x1, e_ht());
    int q = (d > 0) ? d / divtab[m_hsel] : 0;
    return (q < 1) ? 1 : q;
  endfunction
  function automatic int e_h();
    int d = lim(m_y2, e_vt()) - lim(m_y1, e_vt());
    if (d < 0) d = 0;
    return (m_il && m_tall) ? 2 * d : d;
  endfunction
  function automatic int e_even();
    return (m_il && m_tall) ? ((m_dy + (1 - m_field)) % 2) : ((m_dy + m_line) % 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_line = 0; m_field = 0;
      m_pal = 0; m_il = 0; m_tall = 0; m_hsel = 0;
      m_x1 = 608; m_x2 = 3168; m_y1 = 16; m_y2 = 255; m_dy = 0;
      m_hbp = 1; m_vbp = 1;
    end else begin
      m_hbp = e_hb();
      m_vbp = e_vb();
      if (te) begin
        if (m_tick + 1 >= e_ht()) begin
          m_tick = 0;
          if (m_line + 1 >= e_vt()) begin
            if (m_il) begin
              m_field = 1 - m_field;
              m_line  = (m_field == 0) ? 1 : 0;
            end else begin
              m_field = 0;
              m_line  = 0;
            end
          end else m_line = m_line + 1;
          m_pal = rsel; m_il = il; m_tall = tall; m_hsel = {hhi, hlo};
          m_x1 = xs; m_x2 = xe; m_y1 = ys; m_y2 = ye; m_dy = dy;
        end else m_tick = m_tick + 1;
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk && rst_n) begin
      chk("R2", "tick_cnt", int'(o_tick), m_tick);
      chk("R3", "line_cnt", int'(o_line), m_line);
      chk("R3", "field", int'(o_field), m_field);
      chk("R5", "hblank", int'(o_hb), e_hb());
      chk("R6", "vblank", int'(o_vb), e_vb());
      chk("R7", "hblank_pulse", int'(o_hp), (e_hb() == 1 && m_hbp == 0) ? 1 : 0);
      chk("R8", "vblank_irq", int'(o_irq), (e_vb() == 1 && m_vbp == 0) ? 1 : 0);
      chk("R8", "timer_gate", int'(o_gate), e_vb());
      chk("R9", "dot_div", int'(o_div), divtab[m_hsel]);
      chk("R10", "vis_width", int'(o_w), e_w());
      chk("R11", "vis_height", int'(o_h), e_h());
      chk("R12", "even_line", int'(o_even), e_even());
    end
    if (run_chk) te = (($urandom % 4) != 0);
  end

  task automatic set_cfg(int p, int i, int t, int hs, int a, int b, int c, int d, int y);
    @(negedge clk);
    rsel = p[0]; il = i[0]; tall = t[0]; hhi = hs[2]; hlo = hs[1:0];
    xs = 12'(a); xe = 12'(b); ys = 10'(c); ye = 10'(d); dy = 10'(y);
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic small_phase();
    set_cfg(0, 0, 0, 0, 5, 25, 2, 8, 0);         hold(1100);
    set_cfg(1, 1, 1, 1, 4, 28, 1, 9, 3);         hold(1400);   // 480i
    set_cfg(1, 1, 0, 2, 6, 20, 3, 11, 4);        hold(1400);   // interlace, 240 lines
    set_cfg(0, 0, 0, 4, 25, 10, 7, 2, 1);        hold(900);    // end below start
    set_cfg(0, 1, 1, 3, 20, 4000, 4, 1000, 5);   hold(1100);   // beyond totals
    for (int k = 0; k < 8; k++) begin
      set_cfg(k % 2, 0, 0, k, 2, 32, 1, 9, k);   hold(500);
    end
    for (int k = 0; k < 20; k++) begin
      set_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 8,
              $urandom % 40, $urandom % 40, $urandom % 14, $urandom % 14, $urandom % 1024);
      hold(300 + ($urandom % 900));
    end
  endtask

  task automatic line_len(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (f_tick != 12'd0);
  endtask

  task automatic full_phase();
    int n;
    line_len(n);
    chk("R2", "60 Hz line length", n, 3413);
    chk("R2", "line after first wrap", int'(f_line), 1);
    repeat (5) @(negedge clk);
    f_pal = 1'b1;                                // written mid-line
    line_len(n);
    chk("R4", "mid-line change keeps old length", n + 5, 3413);
    line_len(n);
    chk("R2", "50 Hz line length", n, 3406);
    chk("R2", "line count after three lines", int'(f_line), 3);
    chk("R10", "full default width", int'(f_w), (3168 - 608) / 10);
    chk("R11", "full default height", int'(f_h), 255 - 16);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "reset tick", int'(o_tick), 0);
    chk("R1", "reset line", int'(o_line), 0);
    chk("R1", "reset field", int'(o_field), 0);
    chk("R1", "reset hblank_pulse", int'(o_hp), 0);
    chk("R1", "reset vblank_irq", int'(o_irq), 0);
    chk("R1", "reset dot_div", int'(o_div), 10);
    @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1;
    fork
      small_phase();
      full_phase();
    join
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule